// File: doc/BRIEF.md
# Sequential Status Byte Reader on a Two-Wire Bus

This block is a slave on a two-wire serial bus. It lets a bus master read a small bank of status bytes in order. The slave samples the clock and data lines with the system clock and recognises start and stop conditions from those samples. It then takes in an address byte and compares its upper seven bits with a fixed device address. When the address matches and the low bit asks for a read, the slave acknowledges. It then sends bytes from its bank one after another, beginning with entry zero.

The master cannot set the read position. Every start condition sets the pointer back to entry zero. The pointer moves forward by one entry only when the master acknowledges a byte, and it wraps from the last entry back to entry zero. A not-acknowledge from the master ends the transfer. The slave then stays silent until the next start or stop condition.

The local logic fills the bank through a parallel write port. The slave's only output on the bus is an open-drain pull-down enable. The surrounding pad logic combines this enable with the other devices on the line.

Top module: `i2c_seq_reader`

## Requirements
- R1: After reset the slave leaves the data line released (`sdaDriveLow` = 0) and waits for a start condition.
- R2: A start condition, seen as the data line falling while the clock line is high, begins address reception and sets the read pointer to entry 0, so the first byte of every read comes from entry 0.
- R3: The address byte arrives MSB first: seven address bits, then a direction bit where 1 means read. If the seven bits equal `DEV_ADDR` and the direction bit is 1, the slave pulls the data line low during the ninth clock pulse.
- R4: If the address differs, or the direction bit is 0, the slave does not acknowledge and keeps the data line released until the next start or stop.
- R5: Data bytes go out MSB first, and the byte sent at pointer value k is bank entry k.
- R6: When the master holds the data line low on the clock pulse after a byte, the pointer advances by one and the next byte follows. After entry `NUM_BYTES`-1 the pointer wraps to entry 0.
- R7: When the master leaves the data line high after a byte (not-acknowledge), the slave stops sending and keeps the line released for all later clock pulses until a start or stop.
- R8: A start condition in the middle of a transfer (a repeated start) releases the data line and returns the slave to address reception.
- R9: A stop condition, seen as the data line rising while the clock line is high, releases the data line and returns the slave to idle from any state.
- R10: The slave changes its data line drive only while the synchronised clock line is low.
- R11: A write on the load port with `loadEn` = 1 stores `loadData` in entry `loadIdx`, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| loadEn | input | 1 | Write strobe for the bank |
| loadIdx | input | PTR_W | Bank entry written by the load port |
| loadData | input | 8 | Byte written by the load port |

## Verification
The bench runs a long read that crosses the end of the bank, which separates a correct wrap to entry 0 from a pointer that stalls or overruns. It sends a wrong address and a correct address with the write direction bit, which together tell the address compare apart from the direction check. It ends reads with a not-acknowledge, with a repeated start and with a stop placed right after the address acknowledge, and each of these must leave the bus quiet and restart at entry 0. A reload of one entry followed by a read shows that the load port reaches the bytes that go out on the bus.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK,
    ST_NEXT,
    ST_SKIP
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ptrClr;
    logic ptrInc;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_seq_dp.sv
module i2c_seq_dp
  import i2c_seq_pkg::*;
#(
  parameter int NUM_BYTES   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 4,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             loadEn,
  input  logic [PTR_W-1:0] loadIdx,
  input  logic [7:0]       loadData,
  input  dpStrobe_t        stb,
  output logic             sclLvl,
  output logic             sdaLvl,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startDet,
  output logic             stopDet,
  output logic [CNT_W-1:0] bitCnt,
  output logic [7:0]       rxByte,
  output logic             txMsb,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_BYTES - 1);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic                   sclD, sdaD;
  logic [7:0]             txSh;
  logic [7:0]             bank [NUM_BYTES];

  // input synchronisers; the bus idles high
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= sclIn;
          sdaSh <= sdaIn;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
          sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclLvl = sclSh[SYNC_STAGES-1];
  assign sdaLvl = sdaSh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclLvl;
      sdaD <= sdaLvl;
    end
  end

  assign sclRise  = sclLvl & ~sclD;
  assign sclFall  = ~sclLvl & sclD;
  assign startDet = sclLvl & sclD & sdaD & ~sdaLvl;
  assign stopDet  = sclLvl & sclD & ~sdaD & sdaLvl;

  // bit counter and receive shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      if (stb.cntClr)      bitCnt <= '0;
      else if (stb.cntInc) bitCnt <= bitCnt + 1'b1;
      if (stb.rxShift)     rxByte <= {rxByte[6:0], sdaLvl};
    end
  end

  // read pointer with wrap
  always_ff @(posedge clk) begin
    if (!rstN)                           ptr <= '0;
    else if (stb.ptrClr)                 ptr <= '0;
    else if (stb.ptrInc && ptr == LAST_IDX) ptr <= '0;
    else if (stb.ptrInc)                 ptr <= ptr + 1'b1;
  end

  // register bank and transmit shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BYTES; i++) bank[i] <= '0;
    end else if (loadEn && int'(loadIdx) < NUM_BYTES) begin
      bank[loadIdx] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            txSh <= '0;
    else if (stb.txLoad)  txSh <= bank[ptr];
    else if (stb.txShift) txSh <= {txSh[6:0], 1'b0};
  end

  assign txMsb = txSh[7];

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaLvl,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic [7:0]       rxByte,
  input  logic             txMsb,
  output dpStrobe_t        stb,
  output seqState_t        state,
  output logic             driveLow
);

  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);
  localparam logic [7:0]       READ_HDR  = {DEV_ADDR, 1'b1};

  seqState_t nxt;

  always_comb begin
    nxt = state;
    stb = '0;
    if (startDet) begin
      nxt        = ST_ADDR;
      stb.cntClr = 1'b1;
      stb.ptrClr = 1'b1;
    end else if (stopDet) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            stb.cntInc  = 1'b1;
          end else if (sclFall && bitCnt == BYTE_BITS) begin
            nxt = (rxByte == READ_HDR) ? ST_AACK : ST_SKIP;
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            nxt        = ST_TX;
            stb.txLoad = 1'b1;
            stb.cntClr = 1'b1;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            stb.cntInc = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == BYTE_BITS) nxt = ST_MACK;
            else                     stb.txShift = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            if (!sdaLvl) begin
              stb.ptrInc = 1'b1;
              nxt        = ST_NEXT;
            end else begin
              nxt = ST_SKIP;
            end
          end
        end
        ST_NEXT: begin
          if (sclFall) begin
            nxt        = ST_TX;
            stb.txLoad = 1'b1;
            stb.cntClr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign driveLow = (state == ST_AACK) | ((state == ST_TX) & ~txMsb);

endmodule

// File: rtl/i2c_seq_reader.sv
module i2c_seq_reader
  import i2c_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_BYTES   = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDriveLow,
  input  logic             loadEn,
  input  logic [PTR_W-1:0] loadIdx,
  input  logic [7:0]       loadData
);

  localparam int CNT_W = 4;

  dpStrobe_t        stb;
  seqState_t        ctrlState;
  logic             sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet, txMsb;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxByte;
  logic [PTR_W-1:0] ptr;

  i2c_seq_dp #(
    .NUM_BYTES(NUM_BYTES), .SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData), .stb(stb),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt), .rxByte(rxByte),
    .txMsb(txMsb), .ptr(ptr)
  );

  i2c_seq_ctrl #(.DEV_ADDR(DEV_ADDR), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt), .rxByte(rxByte),
    .txMsb(txMsb), .stb(stb), .state(ctrlState), .driveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             driveLow,
  input logic             sclLvl,
  input logic             startDet,
  input logic             stopDet,
  input logic [PTR_W-1:0] ptr,
  input seqState_t        state
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !driveLow); // R1

  AST_START_PTR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (ptr == '0 && state == ST_ADDR)); // R2

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SKIP |-> !driveLow); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> (ptr == '0 || ptr == $past(ptr) + 1'b1)); // R6

  AST_RESTART_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !driveLow); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE && !driveLow)); // R9

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(driveLow) |-> !sclLvl); // R10

endmodule

bind i2c_seq_reader i2c_seq_chk #(.PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .driveLow(sdaDriveLow), .sclLvl(sclLvl),
  .startDet(startDet), .stopDet(stopDet), .ptr(ptr), .state(ctrlState)
);

// File: tb/sim_i2c_seq_reader.sv
`timescale 1ns/1ps
module sim_i2c_seq_reader;

  localparam logic [6:0] ADDR = 7'h2A;
  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       loadEn = 1'b0;
  logic [3:0] loadIdx = '0;
  logic [7:0] loadData = '0;
  logic       sdaDriveLow;
  wire        sdaBus = sdaM & ~sdaDriveLow;

  int nChecks = 0;
  int nBad = 0;

  logic [7:0] expVal[$];
  string      expTag[$];
  logic [7:0] gotByte;
  event       gotEv;

  always #10 clk = ~clk;

  i2c_seq_reader u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData)
  );

  function automatic logic [7:0] initVal(input int i);
    return {1'b1, 7'(i * 7 + 3)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare each received byte with the queue head
  always @(gotEv) begin
    if (expVal.size() == 0) begin
      check(1'b0, "unexpected byte", gotByte, 0);
    end else begin
      automatic logic [7:0] e = expVal.pop_front();
      automatic string t = expTag.pop_front();
      check(gotByte == e, t, gotByte, e);
    end
  end

  // R10: drive may only change while SCL is low
  int  edgeViol = 0;
  logic prevDl = 1'b0;
  logic prevScl = 1'b1;
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && sdaDriveLow != prevDl) edgeViol++;
    prevDl  <= sdaDriveLow;
    prevScl <= sclM;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; w(5); sclM = 1'b1; w(5); sdaM = 1'b0; w(5); sclM = 1'b0; w(5);
  endtask

  task automatic stopC();
    sdaM = 1'b0; w(5); sclM = 1'b1; w(5); sdaM = 1'b1; w(10);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; w(5); sclM = 1'b1; w(10); sclM = 1'b0; w(5);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; w(5); sclM = 1'b1; w(5); b = sdaBus; w(5); sclM = 1'b0; w(5);
  endtask

  task automatic sendHdr(input logic [6:0] a, input logic rd, output logic acked);
    logic [7:0] h;
    logic b;
    h = {a, rd};
    for (int i = 7; i >= 0; i--) sendBit(h[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic rdByte(input bit ack);
    logic [7:0] v;
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      recvBit(b);
      v = {v[6:0], b};
    end
    gotByte = v;
    ->gotEv;
    sendBit(ack ? 1'b0 : 1'b1);
  endtask

  task automatic pushExp(input logic [7:0] v, input string t);
    expVal.push_back(v);
    expTag.push_back(t);
  endtask

  task automatic loadOne(input int i, input logic [7:0] d);
    loadEn = 1'b1; loadIdx = 4'(i); loadData = d; w(1);
    loadEn = 1'b0; w(1);
  endtask

  initial begin
    logic ak;
    w(5);
    rstN = 1'b1;
    w(5);
    check(sdaDriveLow == 1'b0, "R1 reset release", sdaDriveLow, 0);

    for (int i = 0; i < NB; i++) loadOne(i, initVal(i));

    // long read across the end of the bank
    startC();
    sendHdr(ADDR, 1'b1, ak);
    check(ak, "R3 address ack", ak, 1);
    for (int i = 0; i < NB + 2; i++) begin
      pushExp(initVal(i % NB), (i >= NB) ? "R6 wrap" : "R5 byte order");
      rdByte(i < NB + 1);
    end
    stopC();
    check(sdaDriveLow == 1'b0, "R9 stop release", sdaDriveLow, 0);

    // wrong address
    startC();
    sendHdr(7'h15, 1'b1, ak);
    check(!ak, "R4 wrong address nak", ak, 0);
    pushExp(8'hFF, "R4 silent after mismatch");
    rdByte(1'b0);
    stopC();

    // write direction
    startC();
    sendHdr(ADDR, 1'b0, ak);
    check(!ak, "R4 write flag nak", ak, 0);
    stopC();

    // early end by master nak
    startC();
    sendHdr(ADDR, 1'b1, ak);
    check(ak, "R3 ack again", ak, 1);
    pushExp(initVal(0), "R2 first byte");
    pushExp(initVal(1), "R6 step");
    rdByte(1'b1);
    rdByte(1'b0);
    pushExp(8'hFF, "R7 silent after nak");
    rdByte(1'b0);
    stopC();

    // repeated start mid-transfer
    startC();
    sendHdr(ADDR, 1'b1, ak);
    pushExp(initVal(0), "R5 before restart");
    rdByte(1'b1);
    startC();
    check(sdaDriveLow == 1'b0, "R8 restart release", sdaDriveLow, 0);
    sendHdr(ADDR, 1'b1, ak);
    check(ak, "R8 ack after restart", ak, 1);
    pushExp(initVal(0), "R2 restart from entry 0");
    rdByte(1'b0);
    stopC();

    // stop right after the address ack
    startC();
    sendHdr(ADDR, 1'b1, ak);
    stopC();
    check(sdaDriveLow == 1'b0, "R9 stop mid transfer", sdaDriveLow, 0);
    w(20);
    check(sdaDriveLow == 1'b0, "R9 stays idle", sdaDriveLow, 0);

    // reload through the port
    loadOne(2, 8'h5A);
    startC();
    sendHdr(ADDR, 1'b1, ak);
    pushExp(initVal(0), "R11 entry0");
    pushExp(initVal(1), "R11 entry1");
    pushExp(8'h5A, "R11 reloaded entry");
    rdByte(1'b1);
    rdByte(1'b1);
    rdByte(1'b0);
    stopC();

    check(edgeViol == 0, "R10 drive change with scl high", edgeViol, 0);
    check(expVal.size() == 0, "scoreboard drained", expVal.size(), 0);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule